// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects interrupt levels from up to four host-to-card engines, up to four card-to-host engines and up to sixteen user sources, and folds them into one level interrupt toward the host-side message logic. Each group has its own enable mask. Software reads two views of every source. The raw view shows whether the source line is high right now. The masked view shows whether that source is currently asking for service. A bit that is high in the raw view but low in the masked view means only that software has masked the source.

Software services a channel as follows. It clears the channel's enable bit through the clear alias, clears the engine's own status, and then sets the enable bit again through the set alias. The direct mask address also lets software replace the whole mask in one write. All registers sit behind a simple single-cycle register port with one cycle of read latency.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset both enable masks are zero, `host_irq_o` is low and `reg_rdata_o` is zero.
- R2: A write to 0x2010 replaces the channel enable mask with wdata[7:0]. A write to 0x2004 replaces the user enable mask with wdata[15:0]. In both cases the new value is visible from the next clock.
- R3: A write to the set alias (channel 0x2014, user 0x2008) sets every mask bit whose wdata bit is 1 and leaves the other mask bits unchanged.
- R4: A write to the clear alias (channel 0x2018, user 0x200C) clears every mask bit whose wdata bit is 1 and leaves the other mask bits unchanged.
- R5: Reading 0x204C returns the live channel levels. Host-to-card channels 0..3 sit in bits 0..3 and card-to-host channels 0..3 sit in bits 4..7. Reading 0x2048 returns the live user levels in bits 15:0. No level is held after its source drops.
- R6: Reading 0x2044 returns channel levels AND channel mask. Reading 0x2040 returns user levels AND user mask.
- R7: A read of 0x2010 or 0x2004 returns the current channel or user mask, zero-extended to 32 bits.
- R8: `host_irq_o` is the OR of all channel and user request bits, registered once. It follows a source or mask change after exactly one clock.
- R9: Writes to the request, pending or unmapped addresses change no mask bit and do not change `host_irq_o`.
- R10: Read data appears in the cycle after `reg_rd_i` is sampled. Unmapped addresses read zero, and `reg_rdata_o` is zero in any cycle that follows a clock with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h2c_irq_i | input | 4 | Host-to-card engine interrupt levels |
| c2h_irq_i | input | 4 | Card-to-host engine interrupt levels |
| usr_irq_i | input | 16 | User interrupt levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| host_irq_o | output | 1 | Aggregated level interrupt to the host side |

## Verification
A mask write lands on the clock that samples the strobe, so the bench reads it back with a read issued on the next cycle. Read data and `host_irq_o` are both one register deep. The bench therefore changes sources and strobes on the falling edge and samples both outputs on the following falling edge, one rising edge later. The pending and request views read with no extra delay beyond the read register, so the bench holds the sources steady across each read and predicts the value from the levels it drove and its own mask model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int REG_AW = 16;
    localparam int REG_DW = 32;
    localparam int CH_W   = 8;
    localparam int C2H_LSB = 4;

    localparam logic [REG_AW-1:0] USR_MASK_A = 16'h2004;
    localparam logic [REG_AW-1:0] CHN_MASK_A = 16'h2010;
    localparam logic [REG_AW-1:0] USR_REQ_A  = 16'h2040;
    localparam logic [REG_AW-1:0] CHN_REQ_A  = 16'h2044;
    localparam logic [REG_AW-1:0] USR_PEND_A = 16'h2048;
    localparam logic [REG_AW-1:0] CHN_PEND_A = 16'h204C;

    localparam logic [REG_AW-1:0] SET_OFS = 16'h0004;
    localparam logic [REG_AW-1:0] CLR_OFS = 16'h0008;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import dma_irq_pkg::*;
#(
    parameter int               W    = 8,
    parameter logic [REG_AW-1:0] BASE = 16'h2010,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [W-1:0]      mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    logic [W-1:0] wbits;
    logic hit_wr, hit_set, hit_clr;

    always_comb begin
        wbits   = wdata_i[W-1:0] & IMPL;
        hit_wr  = wr_en_i && (addr_i == BASE);
        hit_set = wr_en_i && (addr_i == BASE + SET_OFS);
        hit_clr = wr_en_i && (addr_i == BASE + CLR_OFS);
        st_d = st_q;
        if (hit_wr)
            st_d.mask = wbits;
        else if (hit_set)
            st_d.mask = st_q.mask | wbits;
        else if (hit_clr)
            st_d.mask = st_q.mask & ~wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((mask_o & $past(wbits)) == $past(wbits)));
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((mask_o & $past(wbits)) == '0));
    assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((mask_o & ~$past(wbits)) == ($past(mask_o) & ~$past(wbits))));
    assert_other_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_wr || hit_set || hit_clr) |=> $stable(mask_o));
endmodule

// File: rtl/irq_reg_readback.sv
module irq_reg_readback
    import dma_irq_pkg::*;
#(
    parameter int CW = 8,
    parameter int UW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [CW-1:0]     chn_mask_i,
    input  logic [CW-1:0]     chn_req_i,
    input  logic [CW-1:0]     chn_pend_i,
    input  logic [UW-1:0]     usr_mask_i,
    input  logic [UW-1:0]     usr_req_i,
    input  logic [UW-1:0]     usr_pend_i,
    output logic [REG_DW-1:0] rdata_o
);
    typedef struct packed {
        logic [REG_DW-1:0] rdata;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        if (rd_en_i) begin
            case (addr_i)
                CHN_MASK_A: st_d.rdata = REG_DW'(chn_mask_i);
                CHN_REQ_A:  st_d.rdata = REG_DW'(chn_req_i);
                CHN_PEND_A: st_d.rdata = REG_DW'(chn_pend_i);
                USR_MASK_A: st_d.rdata = REG_DW'(usr_mask_i);
                USR_REQ_A:  st_d.rdata = REG_DW'(usr_req_i);
                USR_PEND_A: st_d.rdata = REG_DW'(usr_pend_i);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rdata_o == '0));
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_H2C = 4,
    parameter int NUM_C2H = 4,
    parameter int NUM_USR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_H2C-1:0]  h2c_irq_i,
    input  logic [NUM_C2H-1:0]  c2h_irq_i,
    input  logic [NUM_USR-1:0]  usr_irq_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic [REG_DW-1:0]   reg_wdata_i,
    output logic [REG_DW-1:0]   reg_rdata_o,
    output logic                host_irq_o
);
    localparam logic [CH_W-1:0] CH_IMPL =
        CH_W'(((1 << NUM_H2C) - 1) | (((1 << NUM_C2H) - 1) << C2H_LSB));

    typedef struct packed {
        logic irq;
    } top_st_t;

    logic [CH_W-1:0]    chn_pend, chn_mask, chn_req;
    logic [NUM_USR-1:0] usr_mask, usr_req;
    logic               any_req;
    top_st_t            st_d, st_q;

    always_comb begin
        chn_pend = '0;
        chn_pend[NUM_H2C-1:0]           = h2c_irq_i;
        chn_pend[C2H_LSB +: NUM_C2H]    = c2h_irq_i;
    end

    irq_mask_bank #(.W(CH_W), .BASE(CHN_MASK_A), .IMPL(CH_IMPL)) chn_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .mask_o(chn_mask)
    );

    irq_mask_bank #(.W(NUM_USR), .BASE(USR_MASK_A), .IMPL('1)) usr_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .mask_o(usr_mask)
    );

    always_comb begin
        chn_req = chn_pend & chn_mask;
        usr_req = usr_irq_i & usr_mask;
        any_req = (|chn_req) | (|usr_req);
        st_d.irq = any_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_irq_o = st_q.irq;

    irq_reg_readback #(.CW(CH_W), .UW(NUM_USR)) rb_i (
        .clk(clk), .rst_n(rst_n), .rd_en_i(reg_rd_i), .addr_i(reg_addr_i),
        .chn_mask_i(chn_mask), .chn_req_i(chn_req), .chn_pend_i(chn_pend),
        .usr_mask_i(usr_mask), .usr_req_i(usr_req), .usr_pend_i(usr_irq_i),
        .rdata_o(reg_rdata_o)
    );

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> host_irq_o);
    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !host_irq_o);
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((chn_mask == '0) && (usr_mask == '0)) |=> !host_irq_o);
endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module dma_irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  h2c = '0, c2h = '0;
    logic [15:0] usr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        hirq;

    int total = 0, bad = 0;
    logic [7:0]  m_c = '0;
    logic [15:0] m_u = '0;

    always #10 clk = ~clk;

    dma_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .h2c_irq_i(h2c), .c2h_irq_i(c2h),
        .usr_irq_i(usr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .host_irq_o(hirq)
    );

    function automatic logic [7:0] pend_c();
        return {c2h, h2c};
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        case (a)
            16'h2010: return {24'd0, m_c};
            16'h2044: return {24'd0, pend_c() & m_c};
            16'h204C: return {24'd0, pend_c()};
            16'h2004: return {16'd0, m_u};
            16'h2040: return {16'd0, usr & m_u};
            16'h2048: return {16'd0, usr};
            default:  return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (|(pend_c() & m_c)) | (|(usr & m_u));
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [31:0] d);
        case (a)
            16'h2010: m_c = d[7:0];
            16'h2014: m_c = m_c | d[7:0];
            16'h2018: m_c = m_c & ~d[7:0];
            16'h2004: m_u = d[15:0];
            16'h2008: m_u = m_u | d[15:0];
            16'h200C: m_u = m_u & ~d[15:0];
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic read_chk(input string req, input logic [15:0] a);
        logic [31:0] d;
        logic [31:0] e;
        reg_read(a, d);
        e = exp_read(a);
        chk(req, d, e);
    endtask

    initial begin
        logic [31:0] d;
        logic [15:0] waddrs [8];
        logic [15:0] raddrs [8];
        void'($urandom(32'd2024));
        waddrs = '{16'h2010, 16'h2014, 16'h2018, 16'h2004, 16'h2008, 16'h200C, 16'h2044, 16'h204C};
        raddrs = '{16'h2010, 16'h2044, 16'h204C, 16'h2004, 16'h2040, 16'h2048, 16'h2000, 16'h2050};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, hirq}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        read_chk("R1 chan mask", 16'h2010);
        read_chk("R1 user mask", 16'h2004);

        // R5 pending with everything masked; R8 no irq
        h2c = 4'b0101; c2h = 4'b1000; usr = 16'h8001;
        read_chk("R5 chan pend", 16'h204C);
        read_chk("R5 user pend", 16'h2048);
        read_chk("R6 chan req masked", 16'h2044);
        chk("R8 irq masked", {31'd0, hirq}, 32'd0);

        // R2 direct write, upper bits ignored
        reg_write(16'h2010, 32'hFFFF_FF80);
        read_chk("R2 chan mask", 16'h2010);
        read_chk("R7 chan mask readback", 16'h2010);
        read_chk("R6 chan req", 16'h2044);
        chk("R8 irq on c2h3", {31'd0, hirq}, {31'd0, exp_irq()});
        reg_write(16'h2004, 32'h1234_0001);
        read_chk("R2 user mask", 16'h2004);
        read_chk("R6 user req", 16'h2040);

        // R3 / R4 aliases
        reg_write(16'h2014, 32'h0000_0005);
        read_chk("R3 chan set", 16'h2010);
        reg_write(16'h2018, 32'h0000_0081);
        read_chk("R4 chan clear", 16'h2010);
        reg_write(16'h2008, 32'h0000_F000);
        read_chk("R3 user set", 16'h2004);
        reg_write(16'h200C, 32'h0000_0001);
        read_chk("R4 user clear", 16'h2004);

        // R9 writes to status/unmapped addresses have no effect
        reg_write(16'h2044, 32'hFFFF_FFFF);
        reg_write(16'h204C, 32'h0000_0000);
        reg_write(16'h2040, 32'hFFFF_FFFF);
        reg_write(16'h2050, 32'hFFFF_FFFF);
        read_chk("R9 chan mask kept", 16'h2010);
        read_chk("R9 user mask kept", 16'h2004);
        chk("R9 irq kept", {31'd0, hirq}, {31'd0, exp_irq()});

        // R5 level not held; R8 one-cycle follow
        reg_write(16'h2010, 32'h0000_00FF);
        @(negedge clk);
        h2c = 4'b0000; c2h = 4'b0000; usr = 16'h0000;
        @(negedge clk);
        chk("R8 irq drops", {31'd0, hirq}, 32'd0);
        read_chk("R5 pend drops", 16'h204C);
        h2c = 4'b0010;
        @(negedge clk);
        chk("R8 irq rises", {31'd0, hirq}, 32'd1);

        // R10 unmapped and idle
        read_chk("R10 unmapped", 16'h2000);
        @(negedge clk);
        chk("R10 idle zero", rdata, 32'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            reg_write(waddrs[$urandom_range(0, 7)], $urandom);
            @(negedge clk);
            h2c = 4'($urandom); c2h = 4'($urandom); usr = 16'($urandom);
            read_chk("R2/R3/R4/R5/R6/R7/R10 random", raddrs[$urandom_range(0, 7)]);
            chk("R8 random irq", {31'd0, hirq}, {31'd0, exp_irq()});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule